// File: doc/BRIEF.md
# NAND Interrupt Status Sequencer

This block sits between a NAND flash command engine and the host. Each cycle it takes the type of the running command, a set of single-cycle event strobes from the datapath (page transfer end, operation failure, locked-block hit, pipeline break, last pipeline page or copyback end, load done, uncorrectable ECC, command done), a DMA-enable flag, the raw ready/busy pin and a watchdog timeout strobe. From these it builds one status word for the flash device and drives an interrupt line.

Ordered events are first captured in a pending set. At most one pending bit is moved into the status word per cycle, always the earliest one in a fixed posting order. That order is consistent with the required sequence for erase, program and read commands, and the DMA-complete bit always comes last. The ready/busy rising edge and reset-command completion bypass the queue. A watchdog timeout leaves only the timeout bit set and discards everything pending. The host clears bits by writing ones. The interrupt line is the OR of the status bits selected by a per-bit mask, gated by a global enable.

Top module: `nand_irq_seq`

## Requirements
- R1: A `wdog_tmo` strobe makes the status word exactly bit 0 on the next edge and discards all pending events. While bit 0 is set, no other bit can become set, and events that arrive in that time are dropped.
- R2: Status bit positions are: 0 timeout, 1 DMA complete, 2 pipeline/copyback complete, 3 locked block, 4 ready/busy rise, 5 reset complete, 6 erase fail, 7 erase complete, 8 pipeline error, 9 page transfer, 10 program fail, 11 program complete, 12 load complete, 13 uncorrectable ECC. An event strobed in one cycle enters a pending set at the next edge. Each later edge moves the first pending bit, in the order 3, 8, 9, 10, 6, 2, 11, 7, 12, 13, 1, into the status word, so at most one queued bit rises per cycle. A repeat of a bit already pending is merged into it.
- R3: `ev_cmd_done` queues DMA complete (bit 1) only for program (`cmd_type`=2) or read (`cmd_type`=3) while `dma_en` is 1. It is posted after every other pending bit.
- R4: For erase (`cmd_type`=1), locked block, erase fail and erase complete strobed together post as bits 3, 6, 7 on successive cycles.
- R5: For program (`cmd_type`=2) with DMA enabled, all events strobed together post as 3, 8, 9, 10, 2, 11, 1.
- R6: For read (`cmd_type`=3) with DMA enabled, all events strobed together post as 8, 9, 2, 12, 13, 1.
- R7: For copyback (`cmd_type`=4), `ev_cmd_done` or `ev_pipe_last` queues bit 2.
- R8: A 0-to-1 change of `rb_pin` sets bit 4 three edges after the pin change is driven. This passes through two synchronizer stages and one edge detector. A 1-to-0 change sets nothing.
- R9: `ev_cmd_done` with `cmd_type`=5 (reset) sets bit 5 on the next edge, without waiting for the queue.
- R10: A host write clears each status bit whose `host_wr_data` bit is 1 and leaves the others alone. A bit that is posted in the same cycle stays set.
- R11: `irq_o` equals `irq_global_en` AND the OR of (`status_o` AND `irq_mask`). It follows the status word in the same cycle.
- R12: Strobes that do not belong to the current command type set nothing. Examples are ECC or load done during program, and any strobe while `cmd_type`=0.
- R13: After reset, `status_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_type | input | 3 | 0 idle, 1 erase, 2 program, 3 read, 4 copyback, 5 reset |
| ev_page_end | input | 1 | End of a page data transfer |
| ev_fail | input | 1 | Program or erase failure |
| ev_locked | input | 1 | Operation hit a locked block |
| ev_pipe_break | input | 1 | Pipeline sequence broken by an intervening access |
| ev_pipe_last | input | 1 | Last page of a pipeline command done |
| ev_load_done | input | 1 | Read load finished |
| ev_ecc_uncor | input | 1 | Uncorrectable ECC error |
| ev_cmd_done | input | 1 | Current command finished |
| dma_en | input | 1 | Data moved by DMA |
| rb_pin | input | 1 | Raw ready/busy pin |
| wdog_tmo | input | 1 | Watchdog timeout strobe |
| host_wr_en | input | 1 | Host write-one-to-clear strobe |
| host_wr_data | input | 14 | Bits to clear |
| irq_mask | input | 14 | Per-bit interrupt enable |
| irq_global_en | input | 1 | Global interrupt enable |
| status_o | output | 14 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a full queue being drained while something else happens at the same time: a watchdog timeout in the middle of the drain, a host clear landing on the very bit being posted, or new events arriving while earlier ones are still pending. Directed sequences strobe every event of a command type in one cycle, then interrupt or clear the drain at chosen cycles. A long run of seeded random strobes, command changes, pin toggles and clears then creates overlaps of pending bits across command types. Every cycle of that run is compared against a cycle-level model in the bench that applies the requirements.

// File: rtl/nisq_pkg.sv
package nisq_pkg;

  localparam int NBITS = 14;
  localparam int NQ    = 11;
  typedef logic [NBITS-1:0] stat_t;

  localparam int B_TMO       = 0;
  localparam int B_DMA       = 1;
  localparam int B_PIPE_DONE = 2;
  localparam int B_LOCKED    = 3;
  localparam int B_RB_RISE   = 4;
  localparam int B_RST_DONE  = 5;
  localparam int B_ERS_FAIL  = 6;
  localparam int B_ERS_DONE  = 7;
  localparam int B_PIPE_ERR  = 8;
  localparam int B_PAGE      = 9;
  localparam int B_PGM_FAIL  = 10;
  localparam int B_PGM_DONE  = 11;
  localparam int B_LOAD      = 12;
  localparam int B_ECC       = 13;

  localparam stat_t QUEUED_MASK = 14'h3FCE;

  typedef enum logic [2:0] {
    CMD_IDLE     = 3'd0,
    CMD_ERASE    = 3'd1,
    CMD_PROG     = 3'd2,
    CMD_READ     = 3'd3,
    CMD_COPYBACK = 3'd4,
    CMD_RESET    = 3'd5
  } cmd_e;

  // Bit index at position k of the posting order (earliest first).
  function automatic int unsigned post_rank_bit(int unsigned k);
    case (k)
      0:       return B_LOCKED;
      1:       return B_PIPE_ERR;
      2:       return B_PAGE;
      3:       return B_PGM_FAIL;
      4:       return B_ERS_FAIL;
      5:       return B_PIPE_DONE;
      6:       return B_PGM_DONE;
      7:       return B_ERS_DONE;
      8:       return B_LOAD;
      9:       return B_ECC;
      default: return B_DMA;
    endcase
  endfunction

  // One-hot of the earliest pending bit in posting order.
  function automatic stat_t pick_next(stat_t pend);
    stat_t r;
    logic  found;
    r     = '0;
    found = 1'b0;
    for (int unsigned k = 0; k < NQ; k++) begin
      if (!found && pend[post_rank_bit(k)]) begin
        r[post_rank_bit(k)] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic stat_t next_status(stat_t cur, stat_t setv, stat_t clrv, logic tmo);
    stat_t r;
    if (tmo) begin
      r        = '0;
      r[B_TMO] = 1'b1;
    end else begin
      r = (cur & ~clrv) | setv;
    end
    return r;
  endfunction

endpackage

// File: rtl/nisq_event_map.sv
module nisq_event_map
  import nisq_pkg::*;
(
  input  logic [2:0] cmd_i,
  input  logic       page_end_i,
  input  logic       fail_i,
  input  logic       locked_i,
  input  logic       pipe_break_i,
  input  logic       pipe_last_i,
  input  logic       load_done_i,
  input  logic       ecc_uncor_i,
  input  logic       cmd_done_i,
  input  logic       dma_en_i,
  output stat_t      queued_o,
  output logic       rst_done_o
);

  cmd_e cmd;
  logic is_er, is_pg, is_rd, is_cb, is_rs;

  assign cmd   = cmd_e'(cmd_i);
  assign is_er = (cmd == CMD_ERASE);
  assign is_pg = (cmd == CMD_PROG);
  assign is_rd = (cmd == CMD_READ);
  assign is_cb = (cmd == CMD_COPYBACK);
  assign is_rs = (cmd == CMD_RESET);

  always_comb begin
    queued_o              = '0;
    queued_o[B_LOCKED]    = locked_i & (is_pg | is_er);
    queued_o[B_PIPE_ERR]  = pipe_break_i & (is_pg | is_rd);
    queued_o[B_PAGE]      = page_end_i & (is_pg | is_rd);
    queued_o[B_PGM_FAIL]  = fail_i & is_pg;
    queued_o[B_ERS_FAIL]  = fail_i & is_er;
    queued_o[B_PIPE_DONE] = (pipe_last_i & (is_pg | is_rd | is_cb)) | (cmd_done_i & is_cb);
    queued_o[B_PGM_DONE]  = cmd_done_i & is_pg;
    queued_o[B_ERS_DONE]  = cmd_done_i & is_er;
    queued_o[B_LOAD]      = load_done_i & is_rd;
    queued_o[B_ECC]       = ecc_uncor_i & is_rd;
    queued_o[B_DMA]       = cmd_done_i & dma_en_i & (is_pg | is_rd);
  end

  assign rst_done_o = cmd_done_i & is_rs;

endmodule

// File: rtl/nisq_post_queue.sv
module nisq_post_queue
  import nisq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush_i,
  input  stat_t ev_i,
  output stat_t post_o
);

  stat_t pend_q;

  assign post_o = pick_next(pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (flush_i) pend_q <= '0;
    else              pend_q <= (pend_q | ev_i) & ~post_o;
  end

  // R2: a single queued bit leaves per cycle
  a_r2_post_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(post_o));

  // R3: a pending DMA bit waits while any other bit is pending
  a_r3_dma_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[B_DMA] && |(pend_q & ~(stat_t'(1) << B_DMA)) && !flush_i) |=> pend_q[B_DMA]);

  // R1: a flush empties the pending set
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (pend_q == '0));

endmodule

// File: rtl/nisq_rb_edge.sv
module nisq_rb_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R8: the edge flag lasts one cycle
  a_r8_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/nand_irq_seq.sv
module nand_irq_seq
  import nisq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_type,
  input  logic             ev_page_end,
  input  logic             ev_fail,
  input  logic             ev_locked,
  input  logic             ev_pipe_break,
  input  logic             ev_pipe_last,
  input  logic             ev_load_done,
  input  logic             ev_ecc_uncor,
  input  logic             ev_cmd_done,
  input  logic             dma_en,
  input  logic             rb_pin,
  input  logic             wdog_tmo,
  input  logic             host_wr_en,
  input  logic [NBITS-1:0] host_wr_data,
  input  logic [NBITS-1:0] irq_mask,
  input  logic             irq_global_en,
  output logic [NBITS-1:0] status_o,
  output logic             irq_o
);

  stat_t status_q, queued_ev, post_w, direct_w, set_w, clr_w;
  logic  rst_done_w, rb_rise_w, tmo_block_w;

  assign tmo_block_w = wdog_tmo | status_q[B_TMO];

  nisq_event_map u_map (
    .cmd_i        (cmd_type),
    .page_end_i   (ev_page_end),
    .fail_i       (ev_fail),
    .locked_i     (ev_locked),
    .pipe_break_i (ev_pipe_break),
    .pipe_last_i  (ev_pipe_last),
    .load_done_i  (ev_load_done),
    .ecc_uncor_i  (ev_ecc_uncor),
    .cmd_done_i   (ev_cmd_done),
    .dma_en_i     (dma_en),
    .queued_o     (queued_ev),
    .rst_done_o   (rst_done_w)
  );

  nisq_post_queue u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (tmo_block_w),
    .ev_i    (queued_ev),
    .post_o  (post_w)
  );

  nisq_rb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (rb_pin),
    .rise_o (rb_rise_w)
  );

  always_comb begin
    direct_w             = '0;
    direct_w[B_RB_RISE]  = rb_rise_w;
    direct_w[B_RST_DONE] = rst_done_w;
  end

  assign set_w = status_q[B_TMO] ? '0 : (post_w | direct_w);
  assign clr_w = host_wr_en ? host_wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, set_w, clr_w, wdog_tmo);
  end

  assign status_o = status_q;
  assign irq_o    = irq_global_en & |(status_q & irq_mask);

  // R1: timeout bit is never accompanied by another bit
  a_r1_tmo_alone: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[B_TMO] |-> ((status_q & ~(stat_t'(1) << B_TMO)) == '0));

  // R2: at most one queued bit rises per cycle
  a_r2_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_q & ~$past(status_q) & QUEUED_MASK) <= 1);

  // R1: timeout strobe leaves exactly the timeout bit
  a_r1_tmo_result: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_tmo |=> (status_q == (stat_t'(1) << B_TMO)));

  // R10: a written one clears a bit that is not being set
  generate
    for (genvar b = 0; b < NBITS; b++) begin : g_w1c
      a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_data[b] && !set_w[b] && !wdog_tmo) |=> !status_q[b]);
    end
  endgenerate

endmodule

// File: tb/nand_irq_seq_tb_top.sv
`timescale 1ns/1ps
module nand_irq_seq_tb_top;

  localparam int NB = 14;
  localparam int ORD[11] = '{3, 8, 9, 10, 6, 2, 11, 7, 12, 13, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd_type = '0;
  logic ev_page_end = 0, ev_fail = 0, ev_locked = 0, ev_pipe_break = 0;
  logic ev_pipe_last = 0, ev_load_done = 0, ev_ecc_uncor = 0, ev_cmd_done = 0;
  logic dma_en = 0, rb_pin = 0, wdog_tmo = 0, host_wr_en = 0, irq_global_en = 1;
  logic [NB-1:0] host_wr_data = '0, irq_mask = '1;
  logic [NB-1:0] status_o;
  logic irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nand_irq_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_type(cmd_type),
    .ev_page_end(ev_page_end), .ev_fail(ev_fail), .ev_locked(ev_locked),
    .ev_pipe_break(ev_pipe_break), .ev_pipe_last(ev_pipe_last),
    .ev_load_done(ev_load_done), .ev_ecc_uncor(ev_ecc_uncor),
    .ev_cmd_done(ev_cmd_done), .dma_en(dma_en), .rb_pin(rb_pin),
    .wdog_tmo(wdog_tmo), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .irq_mask(irq_mask), .irq_global_en(irq_global_en),
    .status_o(status_o), .irq_o(irq_o)
  );

  // ---------------- reference model built from the requirements ----------
  logic [NB-1:0] m_stat, m_pend;
  logic m_s0, m_s1, m_prev;

  function automatic logic [NB-1:0] b_map();
    logic [NB-1:0] v;
    v = '0;
    case (cmd_type)
      3'd1: begin
        v[3] = ev_locked; v[6] = ev_fail; v[7] = ev_cmd_done;
      end
      3'd2: begin
        v[3] = ev_locked; v[8] = ev_pipe_break; v[9] = ev_page_end;
        v[10] = ev_fail; v[2] = ev_pipe_last; v[11] = ev_cmd_done;
        v[1] = ev_cmd_done & dma_en;
      end
      3'd3: begin
        v[8] = ev_pipe_break; v[9] = ev_page_end; v[2] = ev_pipe_last;
        v[12] = ev_load_done; v[13] = ev_ecc_uncor; v[1] = ev_cmd_done & dma_en;
      end
      3'd4: v[2] = ev_pipe_last | ev_cmd_done;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [NB-1:0] b_pick(logic [NB-1:0] p);
    for (int k = 0; k < 11; k++)
      if (p[ORD[k]]) return NB'(1) << ORD[k];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_pend = '0; m_s0 = 0; m_s1 = 0; m_prev = 0;
    end else begin
      logic [NB-1:0] post, dir, ev;
      logic rise;
      rise = m_s1 & ~m_prev;
      ev   = b_map();
      post = b_pick(m_pend);
      dir  = '0;
      dir[4] = rise;
      dir[5] = (cmd_type == 3'd5) & ev_cmd_done;
      if (wdog_tmo) begin
        m_stat = NB'(1);
        m_pend = '0;
      end else begin
        logic blk;
        blk = m_stat[0];
        if (host_wr_en) m_stat = m_stat & ~host_wr_data;
        if (!blk) m_stat = m_stat | post | dir;
        m_pend = blk ? '0 : ((m_pend | ev) & ~post);
      end
      m_prev = m_s1;
      m_s1   = m_s0;
      m_s0   = rb_pin;
    end
  end

  // ---------------- checking helpers -------------------------------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    logic exp_irq;
    @(posedge clk);
    @(negedge clk);
    exp_irq = irq_global_en & |(m_stat & irq_mask);
    chk(tag, 32'(status_o), 32'(m_stat));
    chk("R11", 32'(irq_o), 32'(exp_irq));
  endtask

  task automatic quiet();
    ev_page_end = 0; ev_fail = 0; ev_locked = 0; ev_pipe_break = 0;
    ev_pipe_last = 0; ev_load_done = 0; ev_ecc_uncor = 0; ev_cmd_done = 0;
    wdog_tmo = 0; host_wr_en = 0; host_wr_data = '0;
  endtask

  task automatic wipe();
    host_wr_en = 1; host_wr_data = '1;
    cyc("R10");
    quiet();
    chk("R10", 32'(status_o), 0);
  endtask

  // New bit of each following cycle must match seq[k].
  task automatic expect_seq(input string tag, input int n, input int seq[7]);
    logic [NB-1:0] prev;
    prev = status_o;
    for (int k = 0; k < n; k++) begin
      cyc(tag);
      chk(tag, 32'(status_o & ~prev), 32'(NB'(1) << seq[k]));
      prev = status_o;
    end
    cyc(tag);
    chk(tag, 32'(status_o), 32'(prev));
  endtask

  // ---------------- watchdog ---------------------------------------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ---------------------------------------------
  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk("R13", 32'(status_o), 0);
    chk("R13", 32'(irq_o), 0);
    rst_n = 1;
    cyc("R13");
    chk("R13", 32'(status_o), 0);

    // R5: program, every event together, DMA on
    cmd_type = 3'd2; dma_en = 1;
    ev_locked = 1; ev_pipe_break = 1; ev_page_end = 1; ev_fail = 1;
    ev_pipe_last = 1; ev_cmd_done = 1;
    cyc("R5"); quiet();
    expect_seq("R5", 7, '{3, 8, 9, 10, 2, 11, 1});
    wipe();

    // R6: read, every event together, DMA on
    cmd_type = 3'd3;
    ev_pipe_break = 1; ev_page_end = 1; ev_pipe_last = 1; ev_load_done = 1;
    ev_ecc_uncor = 1; ev_cmd_done = 1;
    cyc("R6"); quiet();
    expect_seq("R6", 6, '{8, 9, 2, 12, 13, 1, 0});
    wipe();

    // R4: erase with locked block and failure
    cmd_type = 3'd1;
    ev_locked = 1; ev_fail = 1; ev_cmd_done = 1;
    cyc("R4"); quiet();
    expect_seq("R4", 3, '{3, 6, 7, 0, 0, 0, 0});
    wipe();

    // R7: copyback done
    cmd_type = 3'd4; ev_cmd_done = 1;
    cyc("R7"); quiet();
    expect_seq("R7", 1, '{2, 0, 0, 0, 0, 0, 0});
    wipe();

    // R3: program done without DMA posts no DMA bit
    cmd_type = 3'd2; dma_en = 0; ev_cmd_done = 1;
    cyc("R3"); quiet();
    expect_seq("R3", 1, '{11, 0, 0, 0, 0, 0, 0});
    chk("R3", 32'(status_o[1]), 0);
    wipe();

    // R12: foreign strobes ignored
    cmd_type = 3'd2; ev_ecc_uncor = 1; ev_load_done = 1;
    cyc("R12"); quiet();
    cmd_type = 3'd0; ev_fail = 1; ev_page_end = 1; ev_cmd_done = 1; ev_locked = 1;
    cyc("R12"); quiet();
    repeat (4) cyc("R12");
    chk("R12", 32'(status_o), 0);

    // R8: ready/busy rise after three edges, fall sets nothing
    rb_pin = 1;
    cyc("R8"); chk("R8", 32'(status_o[4]), 0);
    cyc("R8"); chk("R8", 32'(status_o[4]), 0);
    cyc("R8"); chk("R8", 32'(status_o[4]), 1);
    wipe();
    rb_pin = 0;
    repeat (5) cyc("R8");
    chk("R8", 32'(status_o), 0);

    // R9: reset-command completion on the next edge
    cmd_type = 3'd5; ev_cmd_done = 1;
    cyc("R9"); quiet();
    chk("R9", 32'(status_o), 32'h20);

    // R10: selective clear, and set wins over clear
    cmd_type = 3'd2; dma_en = 0; ev_cmd_done = 1;
    cyc("R10"); quiet();
    host_wr_en = 1; host_wr_data = 14'h0800;
    cyc("R10");
    chk("R10", 32'(status_o), 32'h0820);
    host_wr_data = 14'h0800;
    cyc("R10"); quiet();
    chk("R10", 32'(status_o), 32'h0020);

    // R11: masking and global gate
    irq_mask = 14'h0020; irq_global_en = 0;
    cyc("R11"); chk("R11", 32'(irq_o), 0);
    irq_global_en = 1;
    cyc("R11"); chk("R11", 32'(irq_o), 1);
    irq_mask = 14'h3FDF;
    cyc("R11"); chk("R11", 32'(irq_o), 0);
    irq_mask = '1;
    wipe();

    // R1: timeout in the middle of a drain
    cmd_type = 3'd2; dma_en = 1;
    ev_locked = 1; ev_pipe_break = 1; ev_page_end = 1; ev_cmd_done = 1;
    cyc("R1"); quiet();
    cyc("R1"); cyc("R1");
    wdog_tmo = 1;
    cyc("R1"); quiet();
    chk("R1", 32'(status_o), 1);
    cmd_type = 3'd3; ev_load_done = 1; ev_page_end = 1;
    cyc("R1"); quiet();
    rb_pin = 1;
    repeat (5) cyc("R1");
    chk("R1", 32'(status_o), 1);
    host_wr_en = 1; host_wr_data = 14'h0001; ev_load_done = 1;
    cyc("R1"); quiet();
    repeat (4) cyc("R1");
    chk("R1", 32'(status_o), 0);
    rb_pin = 0;
    repeat (3) cyc("R1");

    // R2: seeded random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      quiet();
      if ($urandom_range(0, 7) == 0) cmd_type = 3'($urandom_range(0, 6));
      if ($urandom_range(0, 15) == 0) dma_en = ~dma_en;
      ev_page_end   = ($urandom_range(0, 4) == 0);
      ev_fail       = ($urandom_range(0, 6) == 0);
      ev_locked     = ($urandom_range(0, 6) == 0);
      ev_pipe_break = ($urandom_range(0, 6) == 0);
      ev_pipe_last  = ($urandom_range(0, 5) == 0);
      ev_load_done  = ($urandom_range(0, 5) == 0);
      ev_ecc_uncor  = ($urandom_range(0, 6) == 0);
      ev_cmd_done   = ($urandom_range(0, 5) == 0);
      wdog_tmo      = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 5) == 0) rb_pin = ~rb_pin;
      if ($urandom_range(0, 7) == 0) begin
        host_wr_en = 1; host_wr_data = NB'($urandom);
      end
      if ($urandom_range(0, 31) == 0) irq_mask = NB'($urandom);
      if ($urandom_range(0, 31) == 0) irq_global_en = ~irq_global_en;
      cyc("R2");
    end
    quiet();
    cyc("R2");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule